// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a memory-mapped watchdog. A free-running counter advances by one on each cycle where the count-enable tick is high and counting is allowed. Every time the counter takes a new value, that value is compared for equality against a programmable match register. A match can set an interrupt flag, change an external match pin, clear and stop the counter, and launch a reset pulse. The pulse goes to the internal reset output only, or to both the internal and external reset outputs. Software can also force either kind of pulse directly.

The pulse length is programmed in count ticks. While a pulse is in flight, further reset requests are dropped. A debug-halt input can freeze the counter when the control register allows it. A sticky reset-cause flag records that the watchdog issued a reset. Only the power-on reset input clears that flag; the ordinary block reset leaves it alone, so software can read it after a watchdog-induced restart.

Software reaches the block through a zero-wait-state bus with select, enable and write strobes and eight word registers. The bus has no data stream, so every pin is a plain level signal.

Top module: `wdog_match_timer`

## Requirements
- R1: Word registers sit at byte offsets 0x00 interrupt flag, 0x04 control, 0x08 counter, 0x0C match actions, 0x10 match value, 0x14 match-pin control, 0x18 pulse length and 0x1C reset cause. An access whose address has bits 1:0 nonzero is ignored. After reset every register reads zero and every output is low.
- R2: With control bit 0 set, the counter rises by one for each cycle in which the tick input is high. With control bit 0 clear, it holds its value.
- R3: While control bit 1 is set, the counter is held at zero. A counter read issued right after the write that sets bit 1 returns zero.
- R4: With control bit 2 set, a high debug-halt input freezes the counter. With bit 2 clear, debug-halt has no effect.
- R5: A match fires once per counter value. A counter that stays at the match value does not fire again after the flag is cleared.
- R6: With match-action bit 0 set, a match sets the interrupt flag (bit 0 at 0x00) one cycle later. The irq output mirrors the flag. Writing 1 to bit 0 clears the flag; writing 0 leaves it unchanged.
- R7: With match-action bit 2 set, a match clears the counter to zero and clears control bit 0.
- R8: Match-pin control bits 5:4 choose the pin action on a match: 0 none, 1 drive low, 2 drive high, 3 toggle. Bit 0 holds the pin state and drives match_out.
- R9: Match-action bit 3 starts an internal reset pulse on a match. Bit 4 starts a pulse on both the internal and external reset outputs. With the tick high every cycle, the pulse lasts (pulse length + 1) cycles.
- R10: Match-action bits 5 (internal) and 6 (internal plus external) start a pulse without a match. Each clears itself once its pulse has started.
- R11: A reset request that arrives while a pulse is active is ignored and does not lengthen the pulse.
- R12: Reset-cause bit 0 goes to 1 when a watchdog pulse starts. The block reset does not clear it; only the power-on reset does.
- R13: Writes to the counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset (keeps reset cause) |
| por_n | input | 1 | Active-low power-on reset (clears everything) |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| cnt_tick | input | 1 | Count-enable tick |
| dbg_halt | input | 1 | Debugger halt indication |
| irq | output | 1 | Match interrupt |
| match_out | output | 1 | External match pin |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset pulse |

## Verification
The bench uses the default 32-bit counter and 16-bit pulse length. Match values stay small (1 to 4), so every match action can be reached within a handful of ticks. Pulse lengths of 3 and 20 are chosen so that a second match lands inside an active pulse, which makes the dropped-request rule visible as an exact cycle count of the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    RI_INT   = 3'd0,
    RI_CTRL  = 3'd1,
    RI_CNT   = 3'd2,
    RI_MACT  = 3'd3,
    RI_MATCH = 3'd4,
    RI_PIN   = 3'd5,
    RI_PLEN  = 3'd6,
    RI_CAUSE = 3'd7
  } reg_idx_e;

  // control bits
  localparam int CT_RUN  = 0;
  localparam int CT_CLR  = 1;
  localparam int CT_FRZ  = 2;
  // match action bits
  localparam int MA_IRQ  = 0;
  localparam int MA_STOP = 2;
  localparam int MA_RINT = 3;
  localparam int MA_REXT = 4;
  localparam int MA_FINT = 5;
  localparam int MA_FEXT = 6;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             clr,
  input  logic             frz_en,
  input  logic             dbg_halt,
  input  logic [CNT_W-1:0] match_val,
  input  logic             match_wr,
  input  logic             stop_on_hit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic             fresh;
  logic             step;
  logic [CNT_W-1:0] cnt_nxt;

  assign step = run_en && tick && !(frz_en && dbg_halt);
  assign hit  = fresh && (cnt == match_val);

  always_comb begin
    cnt_nxt = cnt;
    if (clr || (hit && stop_on_hit)) cnt_nxt = '0;
    else if (step)                   cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if ((cnt_nxt != cnt) || match_wr) fresh <= 1'b1;
      else if (hit)                     fresh <= 1'b0;
    end
  end

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr && !hit) |=> $stable(cnt));
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_en && dbg_halt && !clr && !hit) |=> $stable(cnt));
  // R5
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !match_wr) |=> !hit);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              tick,
  input  logic              start,
  input  logic              ext_req,
  input  logic [PLEN_W-1:0] plen,
  output logic              active,
  output logic              rst_int,
  output logic              rst_ext,
  output logic              cause
);
  logic [PLEN_W-1:0] pcnt;
  logic              ext_r;
  logic              launch;

  assign launch  = start && !active;
  assign rst_int = active;
  assign rst_ext = ext_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ext_r  <= 1'b0;
      pcnt   <= '0;
    end else if (launch) begin
      active <= 1'b1;
      ext_r  <= ext_req;
      pcnt   <= plen;
    end else if (active && tick) begin
      if (pcnt == '0) begin
        active <= 1'b0;
        ext_r  <= 1'b0;
      end else begin
        pcnt <= pcnt - PLEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cause <= 1'b0;
    else if (launch) cause <= 1'b1;
  end

  // R9
  ext_within_int_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ext_r |-> active);
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (active && !tick) |=> (active && $stable(pcnt)));
  // R12
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    launch |=> (cause && active));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [4:0]        paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  input  logic              pulse_active,
  input  logic              cause,
  output logic              run_en,
  output logic              clr,
  output logic              frz_en,
  output logic [CNT_W-1:0]  match_val,
  output logic              match_wr,
  output logic              stop_on_hit,
  output logic              pulse_start,
  output logic              pulse_ext,
  output logic [PLEN_W-1:0] plen,
  output logic              irq,
  output logic              match_out
);
  logic       int_flag;
  logic [2:0] ctrl;
  logic [6:0] mact;
  pin_act_e   pin_act;
  logic       pin_q;
  logic       aligned;
  logic       wr;
  reg_idx_e   idx;
  logic       force_go;

  assign aligned = (paddr[1:0] == 2'b00);
  assign idx     = reg_idx_e'(paddr[4:2]);
  assign wr      = psel && penable && pwrite && aligned;

  assign run_en      = ctrl[CT_RUN];
  assign clr         = ctrl[CT_CLR];
  assign frz_en      = ctrl[CT_FRZ];
  assign stop_on_hit = mact[MA_STOP];
  assign match_wr    = wr && (idx == RI_MATCH);
  assign irq         = int_flag;
  assign match_out   = pin_q;

  assign pulse_start = (hit && (mact[MA_RINT] || mact[MA_REXT])) ||
                       mact[MA_FINT] || mact[MA_FEXT];
  assign pulse_ext   = (hit && mact[MA_REXT]) || mact[MA_FEXT];
  assign force_go    = (mact[MA_FINT] || mact[MA_FEXT]) && !pulse_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_flag  <= 1'b0;
      ctrl      <= '0;
      mact      <= '0;
      match_val <= '0;
      plen      <= '0;
      pin_act   <= PIN_KEEP;
      pin_q     <= 1'b0;
    end else begin
      if (hit && mact[MA_IRQ])                         int_flag <= 1'b1;
      else if (wr && idx == RI_INT && pwdata[0])       int_flag <= 1'b0;

      if (wr && idx == RI_CTRL) ctrl <= pwdata[2:0];
      if (hit && mact[MA_STOP]) ctrl[CT_RUN] <= 1'b0;

      if (wr && idx == RI_MACT) mact <= pwdata[6:0] & 7'b111_1101;
      else if (force_go)        mact[MA_FEXT:MA_FINT] <= 2'b00;

      if (match_wr)             match_val <= pwdata[CNT_W-1:0];
      if (wr && idx == RI_PLEN) plen <= pwdata[PLEN_W-1:0];

      if (wr && idx == RI_PIN) begin
        pin_act <= pin_act_e'(pwdata[5:4]);
        pin_q   <= pwdata[0];
      end
      if (hit) begin
        case (pin_act)
          PIN_LOW:    pin_q <= 1'b0;
          PIN_HIGH:   pin_q <= 1'b1;
          PIN_TOGGLE: pin_q <= ~pin_q;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && aligned) begin
      case (idx)
        RI_INT:   prdata[0] = int_flag;
        RI_CTRL:  prdata[2:0] = ctrl;
        RI_CNT:   prdata[CNT_W-1:0] = cnt;
        RI_MACT:  prdata[6:0] = mact;
        RI_MATCH: prdata[CNT_W-1:0] = match_val;
        RI_PIN:   begin prdata[5:4] = pin_act; prdata[0] = pin_q; end
        RI_PLEN:  prdata[PLEN_W-1:0] = plen;
        RI_CAUSE: prdata[0] = cause;
        default:  prdata = '0;
      endcase
    end
  end

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> $past(hit && mact[MA_IRQ]));
  // R7
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mact[MA_STOP]) |=> !ctrl[CT_RUN]);
  // R10
  force_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_go && !(wr && idx == RI_MACT)) |=> (mact[MA_FEXT:MA_FINT] == 2'b00));
endmodule

// File: rtl/wdog_match_timer.sv
module wdog_match_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PLEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [4:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        cnt_tick,
  input  logic        dbg_halt,
  output logic        irq,
  output logic        match_out,
  output logic        rst_int_o,
  output logic        rst_ext_o
);
  logic              core_rst_n;
  logic [CNT_W-1:0]  cnt;
  logic              hit;
  logic              run_en, clr, frz_en, match_wr, stop_on_hit;
  logic [CNT_W-1:0]  match_val;
  logic              pulse_start, pulse_ext, pulse_active, cause;
  logic [PLEN_W-1:0] plen;

  assign core_rst_n = rst_n & por_n;

  wdt_regs #(.CNT_W(CNT_W), .PLEN_W(PLEN_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .cnt(cnt), .hit(hit), .pulse_active(pulse_active), .cause(cause),
    .run_en(run_en), .clr(clr), .frz_en(frz_en),
    .match_val(match_val), .match_wr(match_wr), .stop_on_hit(stop_on_hit),
    .pulse_start(pulse_start), .pulse_ext(pulse_ext), .plen(plen),
    .irq(irq), .match_out(match_out)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(core_rst_n), .tick(cnt_tick),
    .run_en(run_en), .clr(clr), .frz_en(frz_en), .dbg_halt(dbg_halt),
    .match_val(match_val), .match_wr(match_wr), .stop_on_hit(stop_on_hit),
    .cnt(cnt), .hit(hit)
  );

  wdt_pulse #(.PLEN_W(PLEN_W)) u_pulse (
    .clk(clk), .rst_n(core_rst_n), .por_n(por_n), .tick(cnt_tick),
    .start(pulse_start), .ext_req(pulse_ext), .plen(plen),
    .active(pulse_active), .rst_int(rst_int_o), .rst_ext(rst_ext_o),
    .cause(cause)
  );
endmodule

// File: tb/test_wdog_match_timer.sv
module test_wdog_match_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        cnt_tick = 1'b0, dbg_halt = 1'b0;
  logic        irq, match_out, rst_int_o, rst_ext_o;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_match_timer i_wdog_match_timer (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .cnt_tick(cnt_tick), .dbg_halt(dbg_halt),
    .irq(irq), .match_out(match_out), .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o)
  );

  // monitor: pops expected and observed items and compares them
  initial begin
    forever begin
      wait (act_q.size() != 0);
      begin
        item_t e, a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_checks++;
        if (a.val !== e.val) begin
          n_fails++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a.val, e.val);
        end
      end
    end
  end

  task automatic push(input string tag, input logic [31:0] act, input logic [31:0] exp);
    exp_q.push_back('{tag, exp});
    act_q.push_back('{tag, act});
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] e);
    logic [31:0] d;
    bus_rd(a, d);
    push(tag, d, e);
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1;
    repeat (n) @(negedge clk);
    cnt_tick = 0;
  endtask

  task automatic measure(input int cycles, output int n_int, output int n_ext);
    n_int = 0; n_ext = 0;
    cnt_tick = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_int_o) n_int++;
      if (rst_ext_o) n_ext++;
    end
    cnt_tick = 0;
  endtask

  localparam logic [4:0] A_INT = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08, A_MACT = 5'h0C,
                         A_MATCH = 5'h10, A_PIN = 5'h14, A_PLEN = 5'h18, A_CAUSE = 5'h1C;

  initial begin
    int ni, ne;
    repeat (3) @(negedge clk);
    rst_n = 1; por_n = 1;
    @(negedge clk);
    // R1 reset state
    push("R1 irq after reset", irq, 0);
    push("R1 pins after reset", {match_out, rst_int_o, rst_ext_o}, 0);
    expect_reg("R1 ctrl reset", A_CTRL, 0);
    expect_reg("R1 counter reset", A_CNT, 0);
    expect_reg("R12 cause after power-on", A_CAUSE, 0);
    // R2 counting and holding
    bus_wr(A_CTRL, 1);
    ticks(5);
    expect_reg("R2 count five ticks", A_CNT, 5);
    bus_wr(A_CTRL, 0);
    ticks(3);
    expect_reg("R2 hold when disabled", A_CNT, 5);
    // R13 counter write ignored; R1 misaligned ignored
    bus_wr(A_CNT, 32'h1234);
    expect_reg("R13 counter write ignored", A_CNT, 5);
    bus_wr(5'h11, 32'h77);
    expect_reg("R1 misaligned write ignored", A_MATCH, 0);
    // R3 clear request
    bus_wr(A_CTRL, 2);
    expect_reg("R3 counter cleared", A_CNT, 0);
    ticks(2);
    expect_reg("R3 held at zero", A_CNT, 0);
    // R4 debug freeze
    bus_wr(A_CTRL, 5);
    dbg_halt = 1; ticks(4);
    expect_reg("R4 frozen under halt", A_CNT, 0);
    dbg_halt = 0; ticks(3);
    expect_reg("R4 runs after halt", A_CNT, 3);
    bus_wr(A_CTRL, 1);
    dbg_halt = 1; ticks(2); dbg_halt = 0;
    expect_reg("R4 halt ignored without freeze", A_CNT, 5);
    // R6 / R5 interrupt
    bus_wr(A_CTRL, 2);
    bus_wr(A_MATCH, 4);
    bus_wr(A_MACT, 1);
    bus_wr(A_CTRL, 1);
    ticks(4);
    @(negedge clk);
    push("R6 irq on match", irq, 1);
    bus_wr(A_INT, 0);
    push("R6 write zero keeps flag", irq, 1);
    bus_wr(A_INT, 1);
    push("R6 write one clears flag", irq, 0);
    repeat (3) @(negedge clk);
    expect_reg("R5 no refire at stopped match", A_INT, 0);
    // R8 pin actions
    bus_wr(A_CTRL, 2);
    bus_wr(A_MATCH, 3);
    bus_wr(A_MACT, 0);
    bus_wr(A_PIN, 32'h20);
    bus_wr(A_CTRL, 1);
    ticks(3);
    @(negedge clk);
    push("R8 drive high on match", match_out, 1);
    expect_reg("R8 pin register", A_PIN, 32'h21);
    bus_wr(A_CTRL, 2);
    bus_wr(A_PIN, 32'h31);
    bus_wr(A_CTRL, 1);
    ticks(3);
    @(negedge clk);
    push("R8 toggle on match", match_out, 0);
    bus_wr(A_CTRL, 2);
    bus_wr(A_PIN, 32'h01);
    bus_wr(A_CTRL, 1);
    ticks(3);
    @(negedge clk);
    push("R8 no action keeps pin", match_out, 1);
    bus_wr(A_PIN, 32'h00);
    // R7 stop on match
    bus_wr(A_CTRL, 2);
    bus_wr(A_MATCH, 2);
    bus_wr(A_MACT, 4);
    bus_wr(A_CTRL, 1);
    ticks(4);
    expect_reg("R7 counter cleared on match", A_CNT, 0);
    expect_reg("R7 run bit cleared", A_CTRL, 0);
    // R9 internal pulse
    bus_wr(A_CTRL, 2);
    bus_wr(A_MATCH, 1);
    bus_wr(A_PLEN, 3);
    bus_wr(A_MACT, 8);
    bus_wr(A_CTRL, 1);
    measure(12, ni, ne);
    push("R9 internal pulse length", ni, 4);
    push("R9 no external on internal", ne, 0);
    expect_reg("R12 cause set", A_CAUSE, 1);
    // R9 external pulse
    bus_wr(A_CTRL, 2);
    bus_wr(A_MACT, 32'h10);
    bus_wr(A_CTRL, 1);
    measure(12, ni, ne);
    push("R9 internal with external", ni, 4);
    push("R9 external pulse length", ne, 4);
    // R10 / R11 forced pulse, match during pulse
    bus_wr(A_CTRL, 2);
    bus_wr(A_MATCH, 2);
    bus_wr(A_PLEN, 20);
    bus_wr(A_MACT, 8);
    bus_wr(A_CTRL, 1);
    bus_wr(A_MACT, 32'h28);
    measure(40, ni, ne);
    push("R11 match in pulse ignored", ni, 21);
    push("R10 internal force no external", ne, 0);
    expect_reg("R10 force bit self clears", A_MACT, 8);
    bus_wr(A_CTRL, 0);
    bus_wr(A_MACT, 32'h40);
    @(negedge clk);
    push("R10 external force", {rst_int_o, rst_ext_o}, 2'b11);
    ticks(25);
    push("R10 forced pulse ends", {rst_int_o, rst_ext_o}, 0);
    expect_reg("R10 external force self clears", A_MACT, 0);
    // R12 cause survives block reset
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    expect_reg("R12 cause kept over block reset", A_CAUSE, 1);
    expect_reg("R1 length cleared by block reset", A_PLEN, 0);
    por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    expect_reg("R12 cause cleared by power-on", A_CAUSE, 0);
    wait (act_q.size() == 0);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule